// File: doc/BRIEF.md
# MSI-X Capability Register Controller

This block holds the MSI-X capability structure that sits in a function's configuration space and drives the rescan that follows an unmasking write. Software reads and writes the structure as three dwords, selected by a dword index relative to the capability base, with per-byte lane enables. The identifier, the next-capability link, the table size and the two location registers are fixed by parameters and read-only. Only the enable and function-mask bits in the top byte of the control word can be written.

The vector table engine sits outside this block. It sees the live enable and function-mask bits and the table size. When a write turns delivery on, the controller walks every vector once, from 0 to size-1, one vector per cycle. It presents each index to the engine and asks the engine to deliver that vector if the engine reports it pending and not individually masked.

Top module: `msix_cap_ctrl`

## Requirements
- R1: Dword 0 bits 7:0 read 8'h11 (capability identifier) and bits 15:8 read the NEXT_PTR parameter; no write changes them.
- R2: Dword 0 bits 26:16 read NUM_VECTORS-1 and bits 29:27 read zero; no write changes them; output `table_size` equals NUM_VECTORS.
- R3: Dword 0 bit 31 is the enable and bit 30 the function mask; both reset to 0. They are loaded from `cfg_wdata[31:30]` only by a write to dword 0 with lane enable 3 set. They are mirrored on `msix_enable` and `msix_func_mask` from the cycle after that write.
- R4: Dword 1 reads BAR_IDX (table at offset 0), dword 2 reads 32'h800 OR BAR_IDX, and dword 3 reads zero; writes to dwords 1 to 3 have no effect.
- R5: Read lanes whose enable bit in `cfg_be` is clear return 8'h00. A write with lane enable 3 clear leaves the control bits unchanged.
- R6: A write that takes the enable from 0 to 1, or the function mask from 1 to 0, starts a pass. In the following cycle `scan_busy` is 1 and `scan_vec` is 0. `scan_vec` then rises by one per cycle up to NUM_VECTORS-1, and `scan_busy` is 0 in the cycle after that.
- R7: No other write starts a pass: setting the mask, clearing the enable, rewriting unchanged bits, or writing other lanes or dwords.
- R8: `deliver_req` is 1 in a cycle exactly when `scan_busy`, the enable, `vec_pending` are 1 and the function mask and `vec_masked` are 0. The vector to deliver is `scan_vec`.
- R9: A start condition during a pass restarts the pass at vector 0 in the following cycle.
- R10: After reset, `scan_busy` and `deliver_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the selected dword |
| cfg_dw_sel | input | 2 | Dword index within the capability |
| cfg_be | input | 4 | Byte lane enables for read and write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected dword, masked by lanes |
| msix_enable | output | 1 | Global enable bit |
| msix_func_mask | output | 1 | Function mask bit |
| table_size | output | 12 | Number of table entries |
| scan_busy | output | 1 | Rescan pass in progress |
| scan_vec | output | VEC_W | Vector index under check |
| vec_pending | input | 1 | Pending state of vector `scan_vec` from the table engine |
| vec_masked | input | 1 | Per-vector mask of vector `scan_vec` from the table engine |
| deliver_req | output | 1 | Deliver vector `scan_vec` this cycle |

## Verification
The assertions assume that `vec_pending` and `vec_masked` describe the vector on `scan_vec` in the same cycle. They also assume that control writes arrive only on dword 0 with lane 3 enabled. The bench models the table engine as two fixed bit patterns indexed by `scan_vec`, so the first assumption always holds. Its stimulus drives every input one full cycle at a time, half a period away from the sampling edge. Lane and dword writes that should be ignored are issued too, but as valid write cycles on the same interface.

// File: rtl/msix_cap_pkg.sv
package msix_cap_pkg;
   localparam logic [7:0]  CAP_ID_MSIX = 8'h11;
   localparam logic [31:0] TBL_OFFSET  = 32'h0000_0000;
   localparam logic [31:0] PEND_OFFSET = 32'h0000_0800;
   localparam int          CTRL_LANE   = 3;
   localparam int          EN_BIT      = 31;
   localparam int          FM_BIT      = 30;
   localparam int          MAX_VECTORS = 2048;

   typedef enum logic [1:0] {
      DW_HDR  = 2'd0,
      DW_TBL  = 2'd1,
      DW_PEND = 2'd2,
      DW_NONE = 2'd3
   } dw_sel_e;

   typedef struct packed {
      logic enable;
      logic fmask;
   } ctrl_t;
endpackage

// File: rtl/msix_cap_ctrl_regs.sv
module msix_cap_ctrl_regs
   import msix_cap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [1:0] dw_sel,
   input  logic [3:0] be,
   input  logic [1:0] wr_ctrl,
   output ctrl_t      ctrl,
   output logic       rescan_start
);
   logic  lane_hit;
   ctrl_t ctrl_nxt;

   always_comb begin
      lane_hit = wr && (dw_sel == DW_HDR) && be[CTRL_LANE];
      ctrl_nxt = ctrl;
      if (lane_hit) begin
         ctrl_nxt.enable = wr_ctrl[1];
         ctrl_nxt.fmask  = wr_ctrl[0];
      end
      rescan_start = lane_hit &&
                     ((!ctrl.enable && ctrl_nxt.enable) ||
                      (ctrl.fmask && !ctrl_nxt.fmask));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else begin
         ctrl <= ctrl_nxt;
      end
   end
endmodule

// File: rtl/msix_cap_image.sv
module msix_cap_image
   import msix_cap_pkg::*;
#(
   parameter int         NUM_VECTORS = 8,
   parameter int         BAR_IDX     = 2,
   parameter logic [7:0] NEXT_PTR    = 8'h50
)(
   input  ctrl_t       ctrl,
   input  logic [1:0]  dw_sel,
   input  logic [3:0]  be,
   output logic [31:0] rdata
);
   localparam logic [10:0] SIZE_FIELD = 11'(NUM_VECTORS - 1);
   localparam logic [31:0] BIR        = 32'(BAR_IDX);
   localparam int          LANES      = 4;

   logic [31:0] dw;

   always_comb begin
      unique case (dw_sel_e'(dw_sel))
         DW_HDR:  dw = {ctrl.enable, ctrl.fmask, 3'b000, SIZE_FIELD,
                        NEXT_PTR, CAP_ID_MSIX};
         DW_TBL:  dw = TBL_OFFSET | BIR;
         DW_PEND: dw = PEND_OFFSET | BIR;
         default: dw = '0;
      endcase
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign rdata[8*i +: 8] = be[i] ? dw[8*i +: 8] : 8'h00;
   end
endmodule

// File: rtl/msix_rescan_seq.sv
module msix_rescan_seq #(
   parameter int NUM_VECTORS = 8,
   parameter int VEC_W       = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic [VEC_W-1:0] vec
);
   if (NUM_VECTORS == 1) begin : g_single
      assign vec = '0;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy <= 1'b0;
         end else begin
            busy <= start;
         end
      end
   end else begin : g_multi
      localparam logic [VEC_W-1:0] LAST = VEC_W'(NUM_VECTORS - 1);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy <= 1'b0;
            vec  <= '0;
         end else if (start) begin
            busy <= 1'b1;
            vec  <= '0;
         end else if (busy) begin
            if (vec == LAST) begin
               busy <= 1'b0;
               vec  <= '0;
            end else begin
               vec <= vec + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/msix_cap_ctrl.sv
module msix_cap_ctrl
   import msix_cap_pkg::*;
#(
   parameter int         NUM_VECTORS = 8,
   parameter int         BAR_IDX     = 2,
   parameter logic [7:0] NEXT_PTR    = 8'h50,
   localparam int        VEC_W       = (NUM_VECTORS > 1) ? $clog2(NUM_VECTORS) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [1:0]       cfg_dw_sel,
   input  logic [3:0]       cfg_be,
   input  logic [31:0]      cfg_wdata,
   output logic [31:0]      cfg_rdata,
   output logic             msix_enable,
   output logic             msix_func_mask,
   output logic [11:0]      table_size,
   output logic             scan_busy,
   output logic [VEC_W-1:0] scan_vec,
   input  logic             vec_pending,
   input  logic             vec_masked,
   output logic             deliver_req
);
   if (NUM_VECTORS < 1 || NUM_VECTORS > MAX_VECTORS) begin : g_bad_count
      $error("msix_cap_ctrl: NUM_VECTORS out of range");
   end
   if (BAR_IDX < 0 || BAR_IDX > 5) begin : g_bad_bar
      $error("msix_cap_ctrl: BAR_IDX out of range");
   end

   ctrl_t ctrl;
   logic  rescan_start;

   msix_cap_ctrl_regs regs_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr           (cfg_wr),
      .dw_sel       (cfg_dw_sel),
      .be           (cfg_be),
      .wr_ctrl      (cfg_wdata[EN_BIT:FM_BIT]),
      .ctrl         (ctrl),
      .rescan_start (rescan_start)
   );

   msix_cap_image #(
      .NUM_VECTORS (NUM_VECTORS),
      .BAR_IDX     (BAR_IDX),
      .NEXT_PTR    (NEXT_PTR)
   ) image_i (
      .ctrl   (ctrl),
      .dw_sel (cfg_dw_sel),
      .be     (cfg_be),
      .rdata  (cfg_rdata)
   );

   msix_rescan_seq #(
      .NUM_VECTORS (NUM_VECTORS),
      .VEC_W       (VEC_W)
   ) seq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (rescan_start),
      .busy  (scan_busy),
      .vec   (scan_vec)
   );

   assign msix_enable    = ctrl.enable;
   assign msix_func_mask = ctrl.fmask;
   assign table_size     = 12'(NUM_VECTORS);
   assign deliver_req    = scan_busy && ctrl.enable && !ctrl.fmask &&
                           vec_pending && !vec_masked;
endmodule

// File: rtl/msix_cap_ctrl_chk.sv
module msix_cap_ctrl_chk #(
   parameter int NUM_VECTORS = 8,
   parameter int VEC_W       = 3
)(
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic [1:0]       cfg_dw_sel,
   input logic [3:0]       cfg_be,
   input logic [31:0]      cfg_rdata,
   input logic             msix_enable,
   input logic             msix_func_mask,
   input logic             scan_busy,
   input logic [VEC_W-1:0] scan_vec,
   input logic             vec_pending,
   input logic             vec_masked,
   input logic             deliver_req
);
   logic ctrl_wr;
   assign ctrl_wr = cfg_wr && (cfg_dw_sel == 2'd0) && cfg_be[3];

   assert_cap_id_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dw_sel == 2'd0 && cfg_be[0]) |-> cfg_rdata[7:0] == 8'h11);

   assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable(msix_enable) && $stable(msix_func_mask));

   assert_lane_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_be[1] |-> cfg_rdata[15:8] == 8'h00);

   assert_start_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msix_enable) |-> scan_busy && scan_vec == '0);

   assert_start_fm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(msix_func_mask) |-> scan_busy && scan_vec == '0);

   assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_busy && scan_vec != '0) |-> scan_vec == VEC_W'($past(scan_vec) + 1'b1));

   assert_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scan_busy) |-> $past(scan_vec) == VEC_W'(NUM_VECTORS - 1));

   assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_busy && !$past(scan_busy)) |-> $past(ctrl_wr));

   assert_deliver_R8: assert property (@(posedge clk) disable iff (!rst_n)
      deliver_req |-> scan_busy && msix_enable && !msix_func_mask &&
                      vec_pending && !vec_masked);
endmodule

bind msix_cap_ctrl msix_cap_ctrl_chk #(
   .NUM_VECTORS (NUM_VECTORS),
   .VEC_W       (VEC_W)
) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_wr         (cfg_wr),
   .cfg_dw_sel     (cfg_dw_sel),
   .cfg_be         (cfg_be),
   .cfg_rdata      (cfg_rdata),
   .msix_enable    (msix_enable),
   .msix_func_mask (msix_func_mask),
   .scan_busy      (scan_busy),
   .scan_vec       (scan_vec),
   .vec_pending    (vec_pending),
   .vec_masked     (vec_masked),
   .deliver_req    (deliver_req)
);

// File: tb/msix_cap_ctrl_tb.sv
module msix_cap_ctrl_tb_top;
   localparam int         NV    = 8;
   localparam int         BAR   = 2;
   localparam logic [7:0] NXT   = 8'h50;
   localparam int         VW    = 3;
   localparam int         NTAB  = 8;
   localparam logic [31:0] HDR0 = {5'b0, 11'(NV - 1), NXT, 8'h11};

   // {dword index, lane enables, expected read data}
   localparam logic [37:0] RD_TAB [NTAB] = '{
      {2'd0, 4'hF, HDR0},
      {2'd0, 4'h1, {24'h0, 8'h11}},
      {2'd0, 4'h2, {16'h0, NXT, 8'h00}},
      {2'd0, 4'hC, {HDR0[31:16], 16'h0}},
      {2'd1, 4'hF, 32'(BAR)},
      {2'd2, 4'hF, 32'h800 | 32'(BAR)},
      {2'd2, 4'h2, 32'h0000_0800},
      {2'd3, 4'hF, 32'h0}
   };

   localparam logic [7:0] PEND_PAT = 8'b1011_0110;
   localparam logic [7:0] MASK_PAT = 8'b0010_0100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [1:0]    cfg_dw_sel = 2'd0;
   logic [3:0]    cfg_be = 4'h0;
   logic [31:0]   cfg_wdata = 32'h0;
   logic [31:0]   cfg_rdata;
   logic          msix_enable, msix_func_mask, scan_busy, deliver_req;
   logic [11:0]   table_size;
   logic [VW-1:0] scan_vec;
   logic          vec_pending, vec_masked;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   assign vec_pending = PEND_PAT[scan_vec];
   assign vec_masked  = MASK_PAT[scan_vec];

   msix_cap_ctrl #(.NUM_VECTORS(NV), .BAR_IDX(BAR), .NEXT_PTR(NXT)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw_sel(cfg_dw_sel),
      .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .msix_enable(msix_enable), .msix_func_mask(msix_func_mask),
      .table_size(table_size), .scan_busy(scan_busy), .scan_vec(scan_vec),
      .vec_pending(vec_pending), .vec_masked(vec_masked),
      .deliver_req(deliver_req)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a negedge; write lands on the next posedge, returns at the following negedge
   task automatic do_write(input logic [1:0] sel, input logic [3:0] be, input logic [31:0] d);
      cfg_wr = 1'b1; cfg_dw_sel = sel; cfg_be = be; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = 4'h0; cfg_wdata = 32'h0;
   endtask

   task automatic rd(input logic [1:0] sel, input logic [3:0] be, output logic [31:0] d);
      cfg_dw_sel = sel; cfg_be = be;
      #1 d = cfg_rdata;
   endtask

   task automatic run_pass(input string tag, input logic [7:0] exp_del);
      for (int k = 0; k < NV; k++) begin
         check({tag, " R6 busy"}, 32'(scan_busy), 32'd1);
         check({tag, " R6 index"}, 32'(scan_vec), 32'(k));
         check({tag, " R8 deliver"}, 32'(deliver_req), 32'(exp_del[k]));
         @(negedge clk);
      end
      check({tag, " R6 end"}, 32'(scan_busy), 32'd0);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 / R3 reset state
      check("R10 busy", 32'(scan_busy), 32'd0);
      check("R10 deliver", 32'(deliver_req), 32'd0);
      check("R3 enable reset", 32'(msix_enable), 32'd0);
      check("R3 mask reset", 32'(msix_func_mask), 32'd0);
      check("R2 table_size", 32'(table_size), 32'(NV));

      // read vector table: R1 R2 R4 R5
      for (int i = 0; i < NTAB; i++) begin
         rd(RD_TAB[i][37:36], RD_TAB[i][35:32], d);
         check($sformatf("R1/R2/R4/R5 entry %0d", i), d, RD_TAB[i][31:0]);
      end

      // writes to read-only lanes and dwords
      do_write(2'd0, 4'h7, 32'hFFFF_FFFF);
      rd(2'd0, 4'hF, d);
      check("R1 R2 R5 ro lanes", d, HDR0);
      check("R7 no pass ro write", 32'(scan_busy), 32'd0);
      do_write(2'd0, 4'h7, 32'hC000_0000);
      check("R5 lane3 off enable", 32'(msix_enable), 32'd0);
      do_write(2'd1, 4'hF, 32'hFFFF_FFFF);
      do_write(2'd2, 4'hF, 32'hFFFF_FFFF);
      rd(2'd1, 4'hF, d);
      check("R4 tbl ro", d, 32'(BAR));
      rd(2'd2, 4'hF, d);
      check("R4 pend ro", d, 32'h800 | 32'(BAR));
      check("R7 no pass other dword", 32'(scan_busy), 32'd0);

      // set mask only: no pass
      do_write(2'd0, 4'h8, 32'h4000_0000);
      check("R3 mask set", 32'(msix_func_mask), 32'd1);
      check("R7 mask set no pass", 32'(scan_busy), 32'd0);
      rd(2'd0, 4'hF, d);
      check("R3 image mask", d, HDR0 | 32'h4000_0000);

      // enable with mask held: pass, no delivery
      do_write(2'd0, 4'h8, 32'hC000_0000);
      check("R3 enable set", 32'(msix_enable), 32'd1);
      run_pass("enable-masked", 8'h00);

      // clear mask: pass with delivery of pending unmasked vectors
      do_write(2'd0, 4'h8, 32'h8000_0000);
      run_pass("unmask", PEND_PAT & ~MASK_PAT);

      // rewrite same value: no pass
      do_write(2'd0, 4'h8, 32'h8000_0000);
      check("R7 same value no pass", 32'(scan_busy), 32'd0);

      // retrigger during a pass
      do_write(2'd0, 4'h8, 32'hC000_0000);
      check("R7 set mask no pass", 32'(scan_busy), 32'd0);
      do_write(2'd0, 4'h8, 32'h8000_0000);
      check("R6 start index", 32'(scan_vec), 32'd0);
      @(negedge clk);
      @(negedge clk);
      check("R9 mid index", 32'(scan_vec), 32'd2);
      do_write(2'd0, 4'h8, 32'h0000_0000);
      check("R7 disable keeps pass", 32'(scan_vec), 32'd3);
      check("R8 disabled no deliver", 32'(deliver_req), 32'd0);
      do_write(2'd0, 4'h8, 32'h8000_0000);
      check("R9 restart", 32'(scan_vec), 32'd0);
      run_pass("restart", PEND_PAT & ~MASK_PAT);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule